// File: doc/BRIEF.md
# Frame Alignment Word Detector

This block finds frame boundaries on a receive line that delivers 48 bits per clock with no known bit alignment. Each cycle it joins the word held from the previous cycle with the word now on the line into a 96-bit window. It compares that window against the 48-bit alignment word `F6F6F6282828` (hex) at every one of the 48 possible bit positions at the same time. Until a frame starts, everything on the line is treated as noise.

Once the word is found, the block records its bit position and locks. It then delivers the frame as bit-aligned 48-bit words with a valid flag, starting with the alignment word itself, which is marked by a start-of-frame strobe. While locked, the search is switched off, so alignment-like content inside the payload cannot disturb the frame. After a whole frame has passed (4 rows of 4080 bytes, which is 2720 words), the block unlocks and searches again from the next cycle. This lets frames that follow each other directly be picked up without a gap.

Top module: `faw_delineator`

## Requirements
- R1: A synchronous active-low reset, sampled on a rising clock edge, clears `dout_valid`, `sof`, `in_frame`, `frame_ofs` and `dout` to zero, and abandons any frame in progress.
- R2: No word is marked valid before the alignment word has been detected. After a reset or after a frame ends, line content that does not contain the alignment word produces no valid output.
- R3: The search window is {previous word, current word}, with bit 95 the oldest bit received and the MSB of each word received first. The alignment word is found at any offset from 0 to 47. Offset k means the word occupies window bits 95-k down to 48-k. `frame_ofs` reports k from the first valid word of the frame onwards, and `in_frame` is high from that word on.
- R4: The first valid word of a frame equals `F6F6F6282828`, and `sof` is high for that word only. The output appears one clock after the cycle in which the window holds the complete alignment word.
- R5: Each following valid word is the next 48 line bits in order, cut at the offset captured for the frame.
- R6: A frame yields exactly 2720 valid words on consecutive cycles. `in_frame` is low on the cycle that presents the last of them.
- R7: While a frame is in progress, the search is disabled. An alignment word in the payload, whether word-aligned or at another offset, does not raise `sof` and does not change `frame_ofs`.
- R8: The search is active again on the cycle after the last word of a frame, so an alignment word that directly follows a frame starts a new frame without a lost word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_word | input | 48 | Raw line word, MSB received first |
| dout | output | 48 | Bit-aligned frame word |
| dout_valid | output | 1 | `dout` holds a frame word |
| sof | output | 1 | `dout` holds the alignment word that starts a frame |
| frame_ofs | output | 6 | Bit offset captured for the current frame |
| in_frame | output | 1 | Frame in progress, search disabled |

## Verification
Frames are sent at line shifts chosen to cover offsets 0, 1, a middle value, and one drawn from a seeded random source. Offset 0 shows that a word-aligned frame is found in the held word. Offset 1 shows that the word straddling the far end of the window is found. The random payload shows that realignment is kept for every word of the frame. Two frames sent back to back tell a correct restart on the next cycle apart from a late one. Payloads that carry the alignment word, both word-aligned and straddling two words, tell a suppressed search apart from a search that relocks. A reset in mid-frame followed by plain noise shows that the lock is dropped and that noise stays invalid.

// File: rtl/fawd_pkg.sv
// Package: fawd_pkg
// Shared constants of the frame alignment word detector: line word width,
// alignment word value and the number of line words in one frame.
package fawd_pkg;
    localparam int                 LINE_W      = 48;
    localparam logic [LINE_W-1:0]  ALIGN_WORD  = 48'hF6F6F6282828;
    localparam int                 FRAME_WORDS = 2720;
endpackage

// File: rtl/fawd_window.sv
// Module: fawd_window
// Holds the previous line word and presents a two-word search window,
// oldest bit at the top. Assumes one line word arrives every clock.
module fawd_window #(
    parameter int W = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   din,
    output logic [2*W-1:0] win
);
    logic [W-1:0] prev_q;

    // Keep the word seen in the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= din;
    end

    // Previous word is older, so it sits in the upper half.
    assign win = {prev_q, din};
endmodule

// File: rtl/fawd_search.sv
// Module: fawd_search
// Compares the window with the alignment word at every bit offset in
// parallel. The lowest matching offset, the earliest in bit order, is the
// one reported. Purely combinational; clk and rst_n only time the checks.
module fawd_search #(
    parameter int              W       = 48,
    parameter int              OFS_W   = 6,
    parameter logic [W-1:0]    PATTERN = 48'hF6F6F6282828
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*W-1:0] win,
    output logic           match,
    output logic [OFS_W-1:0] ofs
);
    logic [W-1:0] hits;

    // One comparator per candidate offset.
    for (genvar k = 0; k < W; k++) begin : g_cmp
        assign hits[k] = (win[2*W-1-k -: W] == PATTERN);
    end

    // Priority encode, lowest offset wins.
    always_comb begin
        match = 1'b0;
        ofs   = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hits[k]) begin
                match = 1'b1;
                ofs   = OFS_W'(k);
            end
        end
    end

    // The reported offset points at a comparator that actually fired.
    p_hit_at_ofs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> hits[ofs]);
endmodule

// File: rtl/fawd_realign.sv
// Module: fawd_realign
// Cuts one word out of the window at a bit offset counted from the oldest
// bit. Assumes sel is below W.
module fawd_realign #(
    parameter int W     = 48,
    parameter int OFS_W = 6
) (
    input  logic [2*W-1:0]   win,
    input  logic [OFS_W-1:0] sel,
    output logic [W-1:0]     aligned
);
    logic [2*W-1:0] shifted;

    // Drop the sel oldest bits; the top half is the aligned word.
    always_comb begin
        shifted = win << sel;
        aligned = shifted[2*W-1:W];
    end
endmodule

// File: rtl/fawd_track.sv
// Module: fawd_track
// Frame lock state: accepts a match only while no frame is running, stores
// its offset, counts frame words and registers the aligned output.
// Assumes FRAME_WORDS is at least 2.
module fawd_track #(
    parameter int W           = 48,
    parameter int OFS_W       = 6,
    parameter int FRAME_WORDS = 2720
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             match,
    input  logic [OFS_W-1:0] found_ofs,
    input  logic [W-1:0]     aligned,
    output logic [OFS_W-1:0] sel,
    output logic [W-1:0]     dout_q,
    output logic             valid_q,
    output logic             sof_q,
    output logic             in_frame_q,
    output logic [OFS_W-1:0] ofs_q
);
    localparam int               CNT_W = $clog2(FRAME_WORDS + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_WORDS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    // A match counts only while searching.
    assign accept = match && !in_frame_q;
    // Fresh offset on the starting cycle, stored offset afterwards.
    assign sel    = accept ? found_ofs : ofs_q;

    // Lock, count and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q     <= '0;
            valid_q    <= 1'b0;
            sof_q      <= 1'b0;
            in_frame_q <= 1'b0;
            ofs_q      <= '0;
            cnt_q      <= '0;
        end else begin
            valid_q <= accept || in_frame_q;
            sof_q   <= accept;
            if (accept || in_frame_q) dout_q <= aligned;
            if (accept) begin
                in_frame_q <= 1'b1;
                ofs_q      <= found_ofs;
                cnt_q      <= CNT_W'(1);
            end else if (in_frame_q) begin
                if (cnt_q == LAST) begin
                    in_frame_q <= 1'b0;
                    cnt_q      <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // Start of frame only from a search hit while unlocked.
    p_sof_from_search_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sof_q |-> ($past(match) && !$past(in_frame_q)));
    // Start of frame is always a valid word.
    p_sof_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sof_q |-> valid_q);
    // Offset held for the whole frame.
    p_ofs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_q && !sof_q) |-> $stable(ofs_q));
    // Counter never passes the frame length.
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < FRAME_WORDS);
    // Lock released right after the last word.
    p_end_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_q && cnt_q == LAST && !sof_q) |=> !in_frame_q);
    // Valid words only inside a frame or on its final word.
    p_valid_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (in_frame_q || $past(cnt_q) == LAST));
endmodule

// File: rtl/faw_delineator.sv
// Module: faw_delineator
// Top of the frame alignment word detector: window, parallel search,
// realignment and frame lock. Assumes a continuous 48-bit line word per
// clock, MSB first.
module faw_delineator
    import fawd_pkg::*;
#(
    parameter int              W           = LINE_W,
    parameter logic [W-1:0]    PATTERN     = ALIGN_WORD,
    parameter int              FRAME_LEN   = FRAME_WORDS,
    localparam int             OFS_W       = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     line_word,
    output logic [W-1:0]     dout,
    output logic             dout_valid,
    output logic             sof,
    output logic [OFS_W-1:0] frame_ofs,
    output logic             in_frame
);
    logic [2*W-1:0]   win;
    logic             match;
    logic [OFS_W-1:0] found_ofs;
    logic [OFS_W-1:0] sel;
    logic [W-1:0]     aligned;

    fawd_window #(.W(W)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_word),
        .win   (win)
    );

    fawd_search #(.W(W), .OFS_W(OFS_W), .PATTERN(PATTERN)) u_search (
        .clk   (clk),
        .rst_n (rst_n),
        .win   (win),
        .match (match),
        .ofs   (found_ofs)
    );

    fawd_realign #(.W(W), .OFS_W(OFS_W)) u_realign (
        .win     (win),
        .sel     (sel),
        .aligned (aligned)
    );

    fawd_track #(.W(W), .OFS_W(OFS_W), .FRAME_WORDS(FRAME_LEN)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .match      (match),
        .found_ofs  (found_ofs),
        .aligned    (aligned),
        .sel        (sel),
        .dout_q     (dout),
        .valid_q    (dout_valid),
        .sof_q      (sof),
        .in_frame_q (in_frame),
        .ofs_q      (frame_ofs)
    );
endmodule

// File: tb/faw_delineator_bench.sv
module faw_delineator_bench;
    localparam int          FW  = 2720;
    localparam logic [47:0] PAT = 48'hF6F6F6282828;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] line_word = '0;
    logic [47:0] dout;
    logic        dout_valid, sof, in_frame;
    logic [5:0]  frame_ofs;

    int checks = 0;
    int errors = 0;
    int pend = 0;
    bit done = 1'b0;

    logic [47:0] q_word[$];
    bit          q_sof[$];
    logic [5:0]  q_ofs[$];
    logic [47:0] fr[FW];

    faw_delineator u_faw_delineator (
        .clk(clk), .rst_n(rst_n), .line_word(line_word), .dout(dout),
        .dout_valid(dout_valid), .sof(sof), .frame_ofs(frame_ofs),
        .in_frame(in_frame)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [47:0] rnd48();
        return {16'($urandom), 32'($urandom)};
    endfunction

    // Output monitor: compares each valid word with the expected stream.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dout_valid) begin
                if (q_word.size() == 0) begin
                    chk(1'b0, "R2", "valid word with no frame expected", 64'(dout), 64'(0));
                end else begin
                    logic [47:0] ew;
                    bit          es;
                    logic [5:0]  eo;
                    ew = q_word.pop_front();
                    es = q_sof.pop_front();
                    eo = q_ofs.pop_front();
                    chk(dout == ew, "R5", "aligned word", 64'(dout), 64'(ew));
                    chk(sof == es, "R4/R7", "start strobe", 64'(sof), 64'(es));
                    chk(frame_ofs == eo, "R3/R7", "offset", 64'(frame_ofs), 64'(eo));
                    if (es) begin
                        pend = FW - 1;
                        chk(in_frame == 1'b1, "R3", "in_frame at start", 64'(in_frame), 64'(1));
                    end else if (pend > 0) begin
                        pend--;
                        if (pend == 0)
                            chk(in_frame == 1'b0, "R6", "in_frame on last word", 64'(in_frame), 64'(0));
                    end
                end
            end else if (pend > 0) begin
                chk(1'b0, "R6", "gap inside frame", 64'(0), 64'(1));
                pend = 0;
            end
        end
    end

    // Next virtual stream word: noise, then frames, then noise.
    function automatic logic [47:0] vword(int idx, int pre, int nfr);
        if (idx < pre || idx >= pre + nfr * FW) return rnd48();
        return fr[(idx - pre) % FW];
    endfunction

    // Sends pre noise words, nfr frames and post noise words at line shift s.
    task automatic run(int s, int nfr, int pre, int post, bit embed, int rst_at);
        logic [47:0] vcur, vnext;
        logic [95:0] tmp;
        int total;
        for (int k = 0; k < FW; k++) fr[k] = rnd48();
        fr[0] = PAT;
        if (embed) begin
            fr[100] = PAT;                     // word-aligned copy in payload
            fr[300][23:0]  = PAT[47:24];       // straddling copy at offset 24
            fr[301][47:24] = PAT[23:0];
        end
        for (int f = 0; f < nfr; f++)
            for (int k = 0; k < FW; k++) begin
                q_word.push_back(fr[k]);
                q_sof.push_back(k == 0);
                q_ofs.push_back(6'((48 - s) % 48));
            end
        total = pre + nfr * FW + post;
        vcur  = vword(0, pre, nfr);
        vnext = vword(1, pre, nfr);
        for (int j = 0; j < total - 1; j++) begin
            @(negedge clk);
            if (rst_at < 0 && j >= 2 && j < pre)
                chk(dout_valid == 1'b0, "R2", "noise marked valid", 64'(dout_valid), 64'(0));
            if (j == rst_at) rst_n = 1'b0;
            if (rst_at >= 0 && j == rst_at + 1) begin
                chk(dout_valid == 1'b0, "R1", "valid after reset", 64'(dout_valid), 64'(0));
                chk(in_frame == 1'b0, "R1", "in_frame after reset", 64'(in_frame), 64'(0));
                chk(sof == 1'b0, "R1", "sof after reset", 64'(sof), 64'(0));
                q_word.delete();
                q_sof.delete();
                q_ofs.delete();
                pend = 0;
            end
            if (rst_at >= 0 && j == rst_at + 2) rst_n = 1'b1;
            tmp = {vcur, vnext} << s;
            line_word = tmp[95:48];
            vcur  = vnext;
            vnext = vword(j + 2, pre, nfr);
        end
        repeat (4) @(negedge clk);
        chk(q_word.size() == 0, "R6", "frame words delivered", 64'(q_word.size()), 64'(0));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dout_valid == 1'b0, "R1", "valid in reset", 64'(dout_valid), 64'(0));
        chk(sof == 1'b0, "R1", "sof in reset", 64'(sof), 64'(0));
        chk(in_frame == 1'b0, "R1", "in_frame in reset", 64'(in_frame), 64'(0));
        chk(frame_ofs == 6'd0, "R1", "offset in reset", 64'(frame_ofs), 64'(0));
        chk(dout == 48'd0, "R1", "data in reset", 64'(dout), 64'(0));
        rst_n = 1'b1;
        // R3 R7 R8: two frames back to back with payload copies of the word
        run(5, 2, 40, 20, 1'b1, -1);
        // R3: word-aligned frame, offset 0
        run(0, 1, 10, 20, 1'b0, -1);
        // R3: offset 1, pattern at the far end of the window
        run(47, 1, 10, 20, 1'b0, -1);
        // R5 R8: random shift, two frames
        run(int'($urandom % 48), 2, 12, 20, 1'b1, -1);
        // R1 R2: reset in mid-frame, rest of the line is noise
        run(24, 1, 10, 20, 1'b0, 510);
        // recovery after reset
        run(13, 1, 10, 20, 1'b0, -1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", 200000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule